// File: doc/BRIEF.md
# Posted-Write Register Synchronizer

This block is the register front end of a timer whose counting logic runs on a slow functional clock while software accesses it over a fast interface clock. Ten functional registers cross between the two domains. For each of them the block keeps a bus-side copy, a toggle handshake into the functional domain, and a pending flag that stays set until the functional domain has taken the value. A status word gathers the pending flags so software can see which writes are still in flight.

Software selects one of two write policies through a bit of an interface control register. In posted mode a write to a functional register completes on the bus at once, and the value lands in the functional domain a few cycles later. In non-posted mode the bus is held with a wait signal until the value has landed. Under either policy, a new access to a register whose previous write is still pending is held off, so no earlier value is lost. The wakeup mask, the interface control register and the status word live in the bus domain and never stall. A read of the counter register returns a snapshot of the functional counter that is refreshed continuously through its own handshake.

Top module: `posted_reg_bridge`

## Requirements
- R1: A write to functional register slot i sets bit i of the pending status word (word address 0x12) on the next bus clock. Slot order: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 positive tick increment, 6 negative tick increment, 7 tick count, 8 tick interrupt mask set, 9 tick interrupt mask count. Slot i is at word address i.
- R2: In posted mode, a write to a slot whose pending bit is clear completes in the same cycle, with `bus_wait` low.
- R3: After a write, the functional side raises `fn_stb[i]` for exactly one functional cycle, and `fn_val` slice i carries the written value. The pending bit then clears within a bounded number of bus cycles.
- R4: A write or a read to a slot whose pending bit is set is held with `bus_wait` until the bit clears. Two back-to-back writes to one slot both reach the functional side, in order.
- R5: In non-posted mode, a write to a slot holds `bus_wait` high until its value has landed. When the write completes, the slot's pending bit is already clear.
- R6: Bit 2 of the interface control register (word address 0x10) selects posted mode when it is 1. It reads back as written, and it is 0 after reset.
- R7: The wakeup mask (word address 0x11), the interface control register and the status word have no pending bit and never assert `bus_wait`. The wakeup mask drives `wake_mask` and reads back immediately.
- R8: A read of slot 1 returns the functional counter input `fn_count`, synchronized into the bus domain.
- R9: After reset, `bus_wait` is low, the pending status word is 0 and posted mode is off.
- R10: A read of any slot other than the counter returns the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Interface clock |
| bus_rst | input | 1 | Synchronous active-high reset, interface domain |
| bus_wr | input | 1 | Write request, held until `bus_wait` is low at a rising edge |
| bus_rd | input | 1 | Read request, held until `bus_wait` is low at a rising edge |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high and `bus_wait` is low |
| bus_wait | output | 1 | Stall for the current access |
| wake_mask | output | DATA_W | Wakeup mask register |
| fn_clk | input | 1 | Functional clock |
| fn_rst | input | 1 | Synchronous active-high reset, functional domain |
| fn_count | input | DATA_W | Counter value from the timer logic |
| fn_stb | output | 10 | Per-slot one-cycle update strobe, functional domain |
| fn_val | output | 10*DATA_W | Per-slot landed register values, slot i at bits [i*DATA_W +: DATA_W] |

## Verification
Every slot is written in posted mode with a distinct value. After each write the bench checks that only that slot's bit is pending, that the bit clears, and that exactly one strobe carries the value. This separates a bit-mapping error from a lost or duplicated crossing. The same sweep is then repeated in non-posted mode, where the stall count and the already-landed value at completion tell the two policies apart. Back-to-back writes and a read behind a pending write probe the stall-on-pending rule, and two distinct counter values show that the snapshot path tracks its input rather than a stale copy.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
    localparam int NUM_POSTED = 10;
    localparam int SLOT_W     = $clog2(NUM_POSTED);
    localparam int POSTED_BIT = 2;

    typedef enum logic [SLOT_W-1:0] {
        SL_CTRL     = 4'd0,
        SL_COUNT    = 4'd1,
        SL_LOAD     = 4'd2,
        SL_TRIG     = 4'd3,
        SL_MATCH    = 4'd4,
        SL_TICK_POS = 4'd5,
        SL_TICK_NEG = 4'd6,
        SL_TICK_CNT = 4'd7,
        SL_MASK_SET = 4'd8,
        SL_MASK_CNT = 4'd9
    } slot_e;

    localparam logic [4:0] ADR_IFCTRL = 5'h10;
    localparam logic [4:0] ADR_WAKE   = 5'h11;
    localparam logic [4:0] ADR_PEND   = 5'h12;

    typedef struct packed {
        logic                  hit;
        logic [SLOT_W-1:0]     idx;
    } slot_sel_t;

    function automatic logic [NUM_POSTED-1:0] slot_onehot(input logic [SLOT_W-1:0] idx);
        logic [NUM_POSTED-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_POSTED; k++)
            m[k] = (idx == SLOT_W'(k));
        return m;
    endfunction
endpackage

// File: rtl/pw_sync2.sv
`timescale 1ns/1ps
module pw_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pw_slot.sv
`timescale 1ns/1ps
module pw_slot #(
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              launch,
    input  logic [DATA_W-1:0] wdata,
    output logic              pending,
    output logic [DATA_W-1:0] hold,
    input  logic              fn_clk,
    input  logic              fn_rst,
    output logic              fn_stb,
    output logic [DATA_W-1:0] fn_val
);
    logic req_t, ack_s, req_s, ack_t;

    // bus side: capture value and flip the request toggle
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_t <= 1'b0;
            hold  <= '0;
        end else if (launch) begin
            req_t <= ~req_t;
            hold  <= wdata;
        end
    end

    pw_sync2 u_ack_sync (.clk(bus_clk), .rst(bus_rst), .d(ack_t), .q(ack_s));
    assign pending = req_t ^ ack_s;

    // functional side: take the held value once per toggle, echo it back
    pw_sync2 u_req_sync (.clk(fn_clk), .rst(fn_rst), .d(req_t), .q(req_s));

    always_ff @(posedge fn_clk) begin
        if (fn_rst) begin
            ack_t  <= 1'b0;
            fn_stb <= 1'b0;
            fn_val <= '0;
        end else if (req_s != ack_t) begin
            ack_t  <= req_s;
            fn_stb <= 1'b1;
            fn_val <= hold;
        end else begin
            fn_stb <= 1'b0;
        end
    end

    p_set_r1: assert property (@(posedge bus_clk) disable iff (bus_rst)
        launch |=> pending);
    p_no_launch_pending_r4: assert property (@(posedge bus_clk) disable iff (bus_rst)
        launch |-> !pending);
    p_stb_pulse_r3: assert property (@(posedge fn_clk) disable iff (fn_rst)
        fn_stb |=> !fn_stb);
endmodule

// File: rtl/pw_snap.sv
`timescale 1ns/1ps
module pw_snap #(
    parameter int DATA_W = 32
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    output logic [DATA_W-1:0] cnt_bus,
    input  logic              fn_clk,
    input  logic              fn_rst,
    input  logic [DATA_W-1:0] fn_count
);
    logic              req_t, ack_s, req_s, ack_t;
    logic [DATA_W-1:0] snap;

    pw_sync2 u_ack_sync (.clk(bus_clk), .rst(bus_rst), .d(ack_t), .q(ack_s));

    // bus side: when the echo arrives, take the snapshot and ask again
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_t   <= 1'b0;
            cnt_bus <= '0;
        end else if (ack_s == req_t) begin
            req_t   <= ~req_t;
            cnt_bus <= snap;
        end
    end

    pw_sync2 u_req_sync (.clk(fn_clk), .rst(fn_rst), .d(req_t), .q(req_s));

    always_ff @(posedge fn_clk) begin
        if (fn_rst) begin
            ack_t <= 1'b0;
            snap  <= '0;
        end else if (req_s != ack_t) begin
            ack_t <= req_s;
            snap  <= fn_count;
        end
    end
endmodule

// File: rtl/posted_reg_bridge.sv
`timescale 1ns/1ps
module posted_reg_bridge
    import pw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                         bus_clk,
    input  logic                         bus_rst,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_wait,
    output logic [DATA_W-1:0]            wake_mask,
    input  logic                         fn_clk,
    input  logic                         fn_rst,
    input  logic [DATA_W-1:0]            fn_count,
    output logic [NUM_POSTED-1:0]        fn_stb,
    output logic [NUM_POSTED*DATA_W-1:0] fn_val
);
    localparam int PAD_W = DATA_W - NUM_POSTED;

    slot_sel_t             sel;
    logic                  posted_q;
    logic                  np_busy;
    logic                  cur_pend;
    logic                  launch;
    logic [NUM_POSTED-1:0] launch_v;
    logic [NUM_POSTED-1:0] pending_v;
    logic [DATA_W-1:0]     hold_v [NUM_POSTED];
    logic [DATA_W-1:0]     cnt_bus;

    assign sel.hit  = (bus_addr < ADDR_W'(NUM_POSTED));
    assign sel.idx  = bus_addr[SLOT_W-1:0];
    assign cur_pend = sel.hit && pending_v[sel.idx];

    // wait policy: stall behind a pending slot; non-posted writes also
    // stall from launch until the landed echo clears the pending bit
    always_comb begin
        bus_wait = 1'b0;
        if (bus_wr && sel.hit)
            bus_wait = posted_q ? cur_pend : (!np_busy || cur_pend);
        else if (bus_rd && sel.hit)
            bus_wait = cur_pend;
    end

    assign launch   = bus_wr && sel.hit && !cur_pend && (posted_q || !np_busy);
    assign launch_v = launch ? slot_onehot(sel.idx) : '0;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            np_busy   <= 1'b0;
            posted_q  <= 1'b0;
            wake_mask <= '0;
        end else begin
            if (launch && !posted_q)
                np_busy <= 1'b1;
            else if (np_busy && bus_wr && !cur_pend)
                np_busy <= 1'b0;
            if (bus_wr && !sel.hit) begin
                case (bus_addr)
                    ADDR_W'(ADR_IFCTRL): posted_q  <= bus_wdata[POSTED_BIT];
                    ADDR_W'(ADR_WAKE):   wake_mask <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_POSTED; g++) begin : g_slot
            pw_slot #(.DATA_W(DATA_W)) u_slot (
                .bus_clk (bus_clk),
                .bus_rst (bus_rst),
                .launch  (launch_v[g]),
                .wdata   (bus_wdata),
                .pending (pending_v[g]),
                .hold    (hold_v[g]),
                .fn_clk  (fn_clk),
                .fn_rst  (fn_rst),
                .fn_stb  (fn_stb[g]),
                .fn_val  (fn_val[g*DATA_W +: DATA_W])
            );
        end
    endgenerate

    pw_snap #(.DATA_W(DATA_W)) u_snap (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .cnt_bus  (cnt_bus),
        .fn_clk   (fn_clk),
        .fn_rst   (fn_rst),
        .fn_count (fn_count)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel.hit) begin
            bus_rdata = (sel.idx == SL_COUNT) ? cnt_bus : hold_v[sel.idx];
        end else begin
            case (bus_addr)
                ADDR_W'(ADR_IFCTRL): bus_rdata[POSTED_BIT] = posted_q;
                ADDR_W'(ADR_WAKE):   bus_rdata = wake_mask;
                ADDR_W'(ADR_PEND):   bus_rdata = {{PAD_W{1'b0}}, pending_v};
                default:             bus_rdata = '0;
            endcase
        end
    end

    p_direct_nowait_r7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        ((bus_wr || bus_rd) && !sel.hit) |-> !bus_wait);
    p_posted_accept_r2: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (posted_q && bus_wr && sel.hit && !cur_pend) |-> !bus_wait);
    p_np_stall_r5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (!posted_q && launch) |=> (!bus_wr || bus_wait));
    p_clean_after_reset_r9: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $past(bus_rst) |-> (pending_v == '0 && !np_busy && !posted_q));
endmodule

// File: tb/posted_reg_bridge_test.sv
`timescale 1ns/1ps
module posted_reg_bridge_test;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NS = 10;
    localparam logic [AW-1:0] A_IFC  = 5'h10;
    localparam logic [AW-1:0] A_WAKE = 5'h11;
    localparam logic [AW-1:0] A_PEND = 5'h12;

    logic           bus_clk = 0, fn_clk = 0;
    logic           bus_rst = 1, fn_rst = 1;
    logic           bus_wr = 0, bus_rd = 0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           bus_wait;
    logic [DW-1:0]  wake_mask;
    logic [DW-1:0]  fn_count = '0;
    logic [NS-1:0]  fn_stb;
    logic [NS*DW-1:0] fn_val;

    int errors = 0, checks = 0;
    bit done = 0;
    int stb_cnt [NS];
    logic [DW-1:0] last_v [NS];
    logic [DW-1:0] prev_v [NS];

    always #2.5 bus_clk = ~bus_clk;
    always #18.5 fn_clk = ~fn_clk;

    posted_reg_bridge uut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .wake_mask(wake_mask), .fn_clk(fn_clk),
        .fn_rst(fn_rst), .fn_count(fn_count), .fn_stb(fn_stb), .fn_val(fn_val)
    );

    initial begin
        for (int i = 0; i < NS; i++) begin
            stb_cnt[i] = 0; last_v[i] = '0; prev_v[i] = '0;
        end
    end

    always @(posedge fn_clk) begin
        for (int i = 0; i < NS; i++) begin
            if (!fn_rst && fn_stb[i]) begin
                stb_cnt[i] <= stb_cnt[i] + 1;
                prev_v[i]  <= last_v[i];
                last_v[i]  <= fn_val[i*DW +: DW];
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int st);
        @(negedge bus_clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; st = 0;
        #1;
        while (bus_wait && st < 500) begin
            @(negedge bus_clk); #1; st++;
        end
        @(posedge bus_clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output int st);
        @(negedge bus_clk);
        bus_rd = 1; bus_addr = a; st = 0;
        #1;
        while (bus_wait && st < 500) begin
            @(negedge bus_clk); #1; st++;
        end
        d = bus_rdata;
        @(posedge bus_clk); #1;
        bus_rd = 0;
    endtask

    task automatic wait_idle(output int polls);
        logic [DW-1:0] s;
        int st;
        polls = 0;
        rd(A_PEND, s, st);
        while (s != 0 && polls < 100) begin
            rd(A_PEND, s, st); polls++;
        end
        repeat (20) @(negedge bus_clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i, input int k);
        return 32'h1357_0000 + DW'(i) * 32'h0011_0101 + DW'(k) * 32'h2000_0000;
    endfunction

    initial begin
        repeat (200000) @(posedge bus_clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        int st, polls, base;
        repeat (20) @(negedge bus_clk);
        bus_rst = 0; fn_rst = 0;
        repeat (4) @(negedge bus_clk);

        // R9 reset state
        chk("R9 wait after reset", {31'b0, bus_wait}, 32'd0);
        rd(A_PEND, d, st); chk("R9 pending after reset", d, 32'd0);
        rd(A_IFC, d, st);  chk("R6 R9 posted bit after reset", d, 32'd0);

        // R7 wakeup mask direct
        wr(A_WAKE, 32'hA5A5_0F0F, st); chk("R7 wake write stalls", st, 0);
        rd(A_WAKE, d, st); chk("R7 wake readback", d, 32'hA5A5_0F0F);
        chk("R7 wake_mask port", wake_mask, 32'hA5A5_0F0F);
        rd(A_PEND, d, st); chk("R7 no pending from wake", d, 32'd0);

        // R6 enter posted mode
        wr(A_IFC, 32'h0000_0004, st); chk("R6 ifctrl write stalls", st, 0);
        rd(A_IFC, d, st); chk("R6 ifctrl readback", d, 32'h0000_0004);

        // posted sweep over every slot
        for (int i = 0; i < NS; i++) begin
            base = stb_cnt[i];
            wr(AW'(i), pat(i, 0), st);
            chk($sformatf("R2 posted stalls slot %0d", i), st, 0);
            rd(A_PEND, d, st);
            chk($sformatf("R1 pending map slot %0d", i), d, 32'd1 << i);
            wait_idle(polls);
            chk($sformatf("R3 pending clears slot %0d", i), {31'b0, polls < 100}, 32'd1);
            chk($sformatf("R3 landed value slot %0d", i), fn_val[i*DW +: DW], pat(i, 0));
            chk($sformatf("R3 one strobe slot %0d", i), stb_cnt[i] - base, 1);
            if (i != 1) begin
                rd(AW'(i), d, st);
                chk($sformatf("R10 readback slot %0d", i), d, pat(i, 0));
            end
        end

        // R4 back-to-back writes to one slot
        base = stb_cnt[3];
        wr(AW'(3), 32'h0BAD_0001, st); chk("R4 first write stalls", st, 0);
        wr(AW'(3), 32'h0BAD_0002, st); chk("R4 second write stalled", {31'b0, st > 0}, 32'd1);
        wait_idle(polls);
        chk("R4 both strobes", stb_cnt[3] - base, 2);
        chk("R4 first value kept", prev_v[3], 32'h0BAD_0001);
        chk("R4 last value", last_v[3], 32'h0BAD_0002);

        // R4 read behind pending write; R7 direct access during pending
        wr(AW'(4), 32'h4444_CAFE, st);
        wr(A_WAKE, 32'h0000_0033, st); chk("R7 wake no stall while pending", st, 0);
        rd(A_PEND, d, st); chk("R7 pending visible", d, 32'h0000_0010);
        rd(AW'(4), d, st);
        chk("R4 read stalled", {31'b0, st > 0}, 32'd1);
        chk("R4 read value", d, 32'h4444_CAFE);
        wait_idle(polls);

        // R5 non-posted sweep
        wr(A_IFC, 32'h0, st);
        rd(A_IFC, d, st); chk("R6 posted off readback", d, 32'd0);
        for (int i = 0; i < NS; i++) begin
            base = stb_cnt[i];
            wr(AW'(i), pat(i, 1), st);
            chk($sformatf("R5 nonposted stalls slot %0d", i), {31'b0, st >= 2}, 32'd1);
            chk($sformatf("R5 landed at completion slot %0d", i), fn_val[i*DW +: DW], pat(i, 1));
            rd(A_PEND, d, st);
            chk($sformatf("R5 not pending slot %0d", i), d, 32'd0);
            repeat (20) @(negedge bus_clk);
            chk($sformatf("R5 one strobe slot %0d", i), stb_cnt[i] - base, 1);
        end

        // R8 counter snapshot
        @(negedge fn_clk); fn_count = 32'h1234_5678;
        repeat (100) @(negedge bus_clk);
        rd(AW'(1), d, st); chk("R8 counter read A", d, 32'h1234_5678);
        @(negedge fn_clk); fn_count = 32'hDEAD_BEEF;
        repeat (100) @(negedge bus_clk);
        rd(AW'(1), d, st); chk("R8 counter read B", d, 32'hDEAD_BEEF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule